// File: doc/BRIEF.md
# One-Time-Programmable Memory Command Controller

This block sits between a host bus and the array of a one-time-programmable memory. It watches the bus write strobe, qualifies each write against the chip select, the output enable and a flag that says the programming supply is present, and rejects strobes that are too short to be real. Each qualified write carries a command byte. The controller turns these bytes into a read-source choice (array, status or identifier) and into page programming runs.

A page program starts with a three-byte unlock sequence. Data words then follow, and each one is forwarded to the array model as a page-buffer load. After a quiet interval with no new word, the controller issues a single start pulse to the array. A simplified internal state machine then stays busy for a fixed number of cycles. The status byte reports ready and a sticky failure flag. Only an explicit clear command resets that flag.

Top module: `otp_cmd_ctrl`

## Requirements
- R1: After reset, `rd_sel` is 0 (array), `status` is 8'h80 and neither `prog_wr` nor `prog_go` pulses.
- R2: A write is taken only while `ce_n` is 0, `oe_n` is 1 and `vpp_ok` is 1. Any other combination leaves `rd_sel` and `status` unchanged.
- R3: A write is taken only after `we_n` has been sampled low, with the other qualifiers true, on MIN_LOW consecutive clock edges. A shorter low period has no effect. One low period yields at most one command.
- R4: The command byte is `din[7:0]`. 8'hFF sets `rd_sel` to 0 (array), 8'h70 sets it to 1 (status) and 8'h90 sets it to 2 (identifier).
- R5: `id_word` depends only on `addr[1:0]`. 2'b00 returns MFR_CODE, 2'b01 returns DEV_CODE, and 2'b1x returns zero.
- R6: The bytes 8'hAA, 8'h55, 8'hA0 written in that order enter the page-load phase. A different byte at any step of the sequence, or any unknown byte in read state, sets `rd_sel` to 0.
- R7: In the page-load phase, each accepted write pulses `prog_wr` for one cycle, with `prog_off` = `addr[PAGE_W-1:0]` and `prog_data` = `din`. `rd_sel` reads 1 (status).
- R8: After LOAD_TMO cycles without a new word, `prog_go` pulses once. `status[7]` reads 0 from entry into the page-load phase until exactly PROG_CYC cycles after `prog_go` has been seen.
- R9: If `fail_inject` is 1 during programming, `status[4]` is 1 at completion. Later programming runs and the commands FFh, 70h and 90h never clear it. Only 8'h50 clears it. Status bits other than 7 and 4 read 0.
- R10: Writes that arrive while programming is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| vpp_ok | input | 1 | Programming supply present |
| addr | input | ADDR_W | Bus address |
| din | input | 16 | Bus write data |
| fail_inject | input | 1 | Forces a program failure when high during programming |
| rd_sel | output | 2 | Read source: 0 array, 1 status, 2 identifier |
| status | output | 8 | Status byte: bit 7 ready, bit 4 program fail |
| id_word | output | 16 | Identifier word chosen by addr[1:0] |
| prog_wr | output | 1 | Page-buffer load pulse |
| prog_off | output | PAGE_W | Word offset within the page |
| prog_data | output | 16 | Word to load |
| prog_go | output | 1 | Programming start pulse |

## Verification
If the filter counter or the qualifier is wrong, the first command after reset either flips `rd_sel` when it should not or fails to flip it. This shows within two cycles of the strobe rising. A wrong unlock or load state shows as missing or extra `prog_wr` and `prog_go` pulses, or as `rd_sel` left at status after an abort. A wrong busy counter shifts the rise of `status[7]` away from exactly PROG_CYC cycles after `prog_go`. A sticky flag that is cleared by the wrong event shows in `status[4]` on the next read after that event.

// File: rtl/otp_cmd_pkg.sv
package otp_cmd_pkg;
    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_STATUS = 2'd1,
        SRC_ID     = 2'd2
    } rd_src_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_UNLK1 = 3'd1,
        ST_UNLK2 = 3'd2,
        ST_LOAD  = 3'd3,
        ST_PROG  = 3'd4
    } fsm_e;

    localparam logic [7:0] CMD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_STATUS = 8'h70;
    localparam logic [7:0] CMD_CLEAR  = 8'h50;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] KEY_1      = 8'hAA;
    localparam logic [7:0] KEY_2      = 8'h55;
    localparam logic [7:0] KEY_3      = 8'hA0;
endpackage

// File: rtl/otp_wr_qual.sv
module otp_wr_qual #(
    parameter int ADDR_W  = 8,
    parameter int MIN_LOW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              vpp_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       din,
    output logic              stb_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [15:0]       data_o
);
    localparam int CNT_W = $clog2(MIN_LOW + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              fired;
        logic              stb;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       data;
    } qual_t;

    qual_t q, d;
    logic  wr_ok;

    assign wr_ok = !we_n && !ce_n && oe_n && vpp_ok;

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        if (!wr_ok) begin
            d.cnt   = '0;
            d.fired = 1'b0;
        end else if (!q.fired) begin
            if (q.cnt == CNT_W'(MIN_LOW - 1)) begin
                d.stb   = 1'b1;
                d.fired = 1'b1;
                d.addr  = addr;
                d.data  = din;
                d.cnt   = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stb_o  = q.stb;
    assign addr_o = q.addr;
    assign data_o = q.data;

    // R2
    stb_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> $past(wr_ok));
    // R3
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> !stb_o);
endmodule

// File: rtl/otp_cmd_fsm.sv
module otp_cmd_fsm
    import otp_cmd_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int PAGE_W   = 3,
    parameter int LOAD_TMO = 16,
    parameter int PROG_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       data_i,
    input  logic              fail_inject,
    output logic [1:0]        rd_sel,
    output logic [7:0]        status,
    output logic              prog_wr,
    output logic [PAGE_W-1:0] prog_off,
    output logic [15:0]       prog_data,
    output logic              prog_go
);
    localparam int MAX_CNT = (LOAD_TMO > PROG_CYC) ? LOAD_TMO : PROG_CYC;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    typedef struct packed {
        fsm_e              st;
        rd_src_e           src;
        logic              ready;
        logic              fail;
        logic              fail_seen;
        logic [CNT_W-1:0]  cnt;
        logic              pwr;
        logic [PAGE_W-1:0] poff;
        logic [15:0]       pdata;
        logic              go;
    } ctl_t;

    ctl_t       q, d;
    logic [7:0] cmd;

    assign cmd = data_i[7:0];

    always_comb begin
        d     = q;
        d.pwr = 1'b0;
        d.go  = 1'b0;
        unique case (q.st)
            ST_IDLE: if (stb_i) begin
                unique case (cmd)
                    CMD_ARRAY:  d.src  = SRC_ARRAY;
                    CMD_STATUS: d.src  = SRC_STATUS;
                    CMD_CLEAR:  d.fail = 1'b0;
                    CMD_IDENT:  d.src  = SRC_ID;
                    KEY_1:      d.st   = ST_UNLK1;
                    default:    d.src  = SRC_ARRAY;
                endcase
            end
            ST_UNLK1: if (stb_i) begin
                if (cmd == KEY_2) d.st = ST_UNLK2;
                else begin
                    d.st  = ST_IDLE;
                    d.src = SRC_ARRAY;
                end
            end
            ST_UNLK2: if (stb_i) begin
                if (cmd == KEY_3) begin
                    d.st    = ST_LOAD;
                    d.src   = SRC_STATUS;
                    d.ready = 1'b0;
                    d.cnt   = '0;
                end else begin
                    d.st  = ST_IDLE;
                    d.src = SRC_ARRAY;
                end
            end
            ST_LOAD: begin
                if (stb_i) begin
                    d.pwr   = 1'b1;
                    d.poff  = addr_i[PAGE_W-1:0];
                    d.pdata = data_i;
                    d.cnt   = '0;
                end else if (q.cnt == CNT_W'(LOAD_TMO - 1)) begin
                    d.st        = ST_PROG;
                    d.go        = 1'b1;
                    d.cnt       = '0;
                    d.fail_seen = 1'b0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_PROG: begin
                if (fail_inject) d.fail_seen = 1'b1;
                if (q.cnt == CNT_W'(PROG_CYC - 1)) begin
                    d.st    = ST_IDLE;
                    d.ready = 1'b1;
                    d.fail  = q.fail | q.fail_seen | fail_inject;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.src   <= SRC_ARRAY;
            q.ready <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_sel    = q.src;
    assign status    = {q.ready, 2'b00, q.fail, 4'b0000};
    assign prog_wr   = q.pwr;
    assign prog_off  = q.poff;
    assign prog_data = q.pdata;
    assign prog_go   = q.go;

    // R9
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.fail) |-> $past(stb_i && cmd == CMD_CLEAR && q.st == ST_IDLE));
    // R8
    ready_after_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ready) |-> $past(q.st == ST_PROG));
    // R7
    load_only_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_wr |-> $past(q.st == ST_LOAD && stb_i));
    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PROG && stb_i) |=> $stable(q.src));
endmodule

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl #(
    parameter int          ADDR_W   = 8,
    parameter int          PAGE_W   = 3,
    parameter int          MIN_LOW  = 3,
    parameter int          LOAD_TMO = 16,
    parameter int          PROG_CYC = 40,
    parameter logic [15:0] MFR_CODE = 16'h005A,
    parameter logic [15:0] DEV_CODE = 16'h1D3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              vpp_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       din,
    input  logic              fail_inject,
    output logic [1:0]        rd_sel,
    output logic [7:0]        status,
    output logic [15:0]       id_word,
    output logic              prog_wr,
    output logic [PAGE_W-1:0] prog_off,
    output logic [15:0]       prog_data,
    output logic              prog_go
);
    logic              stb;
    logic [ADDR_W-1:0] stb_addr;
    logic [15:0]       stb_data;

    otp_wr_qual #(.ADDR_W(ADDR_W), .MIN_LOW(MIN_LOW)) u_qual (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .vpp_ok(vpp_ok), .addr(addr), .din(din),
        .stb_o(stb), .addr_o(stb_addr), .data_o(stb_data)
    );

    otp_cmd_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .LOAD_TMO(LOAD_TMO),
                  .PROG_CYC(PROG_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .stb_i(stb), .addr_i(stb_addr),
        .data_i(stb_data), .fail_inject(fail_inject), .rd_sel(rd_sel),
        .status(status), .prog_wr(prog_wr), .prog_off(prog_off),
        .prog_data(prog_data), .prog_go(prog_go)
    );

    always_comb begin
        unique case (addr[1:0])
            2'b00:   id_word = MFR_CODE;
            2'b01:   id_word = DEV_CODE;
            default: id_word = 16'h0000;
        endcase
    end
endmodule

// File: tb/otp_cmd_ctrl_bench.sv
module otp_cmd_ctrl_bench;
    localparam int ADDR_W = 8, PAGE_W = 3, MIN_LOW = 3, LOAD_TMO = 16, PROG_CYC = 40;
    localparam logic [15:0] MFR = 16'h005A, DEV = 16'h1D3C;

    logic clk = 0, rst_n = 0;
    logic ce_n = 1, oe_n = 1, we_n = 1, vpp_ok = 0, fail_inject = 0;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0] din = '0;
    logic [1:0] rd_sel;
    logic [7:0] status;
    logic [15:0] id_word, prog_data;
    logic prog_wr, prog_go;
    logic [PAGE_W-1:0] prog_off;

    int tests = 0, fails = 0;
    int wr_cnt = 0, go_cnt = 0;
    logic [PAGE_W-1:0] last_off;
    logic [15:0] last_data;

    always #5 clk = ~clk;

    otp_cmd_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .MIN_LOW(MIN_LOW),
                   .LOAD_TMO(LOAD_TMO), .PROG_CYC(PROG_CYC),
                   .MFR_CODE(MFR), .DEV_CODE(DEV)) u_otp_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .vpp_ok(vpp_ok), .addr(addr), .din(din), .fail_inject(fail_inject),
        .rd_sel(rd_sel), .status(status), .id_word(id_word),
        .prog_wr(prog_wr), .prog_off(prog_off), .prog_data(prog_data),
        .prog_go(prog_go)
    );

    always @(negedge clk) begin
        if (prog_wr) begin
            wr_cnt++;
            last_off  = prog_off;
            last_data = prog_data;
        end
        if (prog_go) go_cnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] dt, input int low);
        @(negedge clk);
        addr = a; din = dt; we_n = 0;
        repeat (low) @(negedge clk);
        we_n = 1;
        repeat (2) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] c);
        wr('0, {8'h00, c}, MIN_LOW);
    endtask

    task automatic unlock();
        cmd(8'hAA); cmd(8'h55); cmd(8'hA0);
    endtask

    task automatic wait_go();
        int n = 0;
        while (!prog_go && n < 500) begin @(negedge clk); n++; end
        chk(prog_go, "R8 go", int'(prog_go), 1);
    endtask

    task automatic wait_ready(output int lat);
        lat = 0;
        while (!status[7] && lat < 1000) begin @(negedge clk); lat++; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int lat, w0, g0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(rd_sel == 0, "R1 rd_sel", rd_sel, 0);
        chk(status == 8'h80, "R1 status", status, 8'h80);
        chk(!prog_wr && !prog_go, "R1 pulses", {prog_wr, prog_go}, 0);

        // R2 qualifier sweep: only ce_n=0, oe_n=1, vpp_ok=1 takes the write
        for (int m = 0; m < 8; m++) begin
            ce_n = m[0]; oe_n = m[1]; vpp_ok = m[2];
            cmd(8'h70);
            if (m == 6) chk(rd_sel == 1, "R2 accepted", rd_sel, 1);
            else        chk(rd_sel == 0, "R2 ignored", rd_sel, 0);
            ce_n = 0; oe_n = 1; vpp_ok = 1;
            cmd(8'hFF);
        end

        // R3 strobe width sweep
        for (int n = 1; n <= MIN_LOW + 2; n++) begin
            wr('0, 16'h0070, n);
            chk((rd_sel == 1) == (n >= MIN_LOW), "R3 width", rd_sel, (n >= MIN_LOW) ? 1 : 0);
            cmd(8'hFF);
            chk(rd_sel == 0, "R4 array", rd_sel, 0);
        end

        // R4 identifier and status
        cmd(8'h90);
        chk(rd_sel == 2, "R4 ident", rd_sel, 2);
        // R5 identifier address sweep over all upper-bit patterns
        for (int a = 0; a < 256; a++) begin
            logic [15:0] e;
            addr = 8'(a);
            #1;
            e = (a[1:0] == 2'b00) ? MFR : (a[1:0] == 2'b01) ? DEV : 16'h0;
            chk(id_word == e, "R5 id", id_word, e);
        end
        cmd(8'h70);
        chk(rd_sel == 1, "R4 status", rd_sel, 1);

        // R6 abort at each step of the unlock sequence
        cmd(8'hAA); cmd(8'h12);
        chk(rd_sel == 0, "R6 abort1", rd_sel, 0);
        cmd(8'h70); cmd(8'hAA); cmd(8'h55); cmd(8'h13);
        chk(rd_sel == 0, "R6 abort2", rd_sel, 0);
        cmd(8'h70); cmd(8'h3C);
        chk(rd_sel == 0, "R6 unknown", rd_sel, 0);
        chk(wr_cnt == 0 && go_cnt == 0, "R6 no prog", wr_cnt + go_cnt, 0);

        // R7 R8 page program without failure
        unlock();
        chk(rd_sel == 1, "R7 status src", rd_sel, 1);
        chk(status == 8'h00, "R8 busy", status, 8'h00);
        w0 = wr_cnt; g0 = go_cnt;
        for (int k = 0; k < 8; k++) begin
            wr(8'(8'hA0 + 7 - k), 16'hC300 + 16'(k * 17), MIN_LOW);
            chk(wr_cnt == w0 + k + 1, "R7 wr pulse", wr_cnt - w0, k + 1);
            chk(last_off == PAGE_W'(7 - k), "R7 offset", last_off, 7 - k);
            chk(last_data == 16'hC300 + 16'(k * 17), "R7 data", last_data, 16'hC300 + k * 17);
        end
        chk(go_cnt == g0, "R8 no early go", go_cnt - g0, 0);
        wait_go();
        chk(status[7] == 0, "R8 busy at go", status, 0);
        wait_ready(lat);
        chk(lat == PROG_CYC, "R8 busy length", lat, PROG_CYC);
        chk(status == 8'h80, "R9 no fail", status, 8'h80);
        chk(go_cnt == g0 + 1, "R8 one go", go_cnt - g0, 1);

        // R9 failure injected during programming
        fail_inject = 1;
        unlock();
        wr(8'h01, 16'h1111, MIN_LOW);
        wait_go();
        wait_ready(lat);
        fail_inject = 0;
        chk(status == 8'h90, "R9 fail set", status, 8'h90);
        cmd(8'hFF); cmd(8'h90); cmd(8'h70);
        chk(status == 8'h90, "R9 sticky cmds", status, 8'h90);
        // R10 write during busy ignored; R9 fail survives a clean run
        unlock();
        wr(8'h02, 16'h2222, MIN_LOW);
        wait_go();
        cmd(8'hFF);
        chk(rd_sel == 1, "R10 busy ignore", rd_sel, 1);
        cmd(8'h50);
        chk(status == 8'h10, "R10 clear ignored busy", status, 8'h10);
        wait_ready(lat);
        chk(status == 8'h90, "R9 sticky prog", status, 8'h90);
        cmd(8'h50);
        chk(status == 8'h80, "R9 clear", status, 8'h80);
        chk(rd_sel == 1, "R9 clear keeps src", rd_sel, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule